// File: doc/BRIEF.md
# Grouped Priority-Field Interrupt Controller

The block arbitrates among thirteen level-sensitive peripheral interrupt requests. Software enables each source by writing a non-zero 4-bit level into a nibble of one of three 16-bit level registers. Some nibbles stand for a whole group of sources, for example the two capture/underflow lines of a timer or the four lines of a serial port. Writing a non-zero value to such a nibble enables every member at that level. A third group of sources also needs a bit in a 32-bit gate register. Software writes that register through two word addresses: one ORs the written value in, the other clears the bits where the written value has a 1.

A source takes part in arbitration only when every nibble and every gate bit that refers to it is non-zero. Among the pending and enabled sources, the one with the highest level wins and drives a request flag, its level and its 12-bit vector code. The result is registered, so it reaches the outputs one clock after it is resolved. All register reads are combinational on the word address.

Top module: `intc_grouped`

## Requirements
- R1: After reset every level register and the gate register read zero, and `irq_o`, `irq_level_o` and `irq_vector_o` are 0, so no source is enabled.
- R2: Word addresses 0, 1 and 2 are level registers holding bus data bits 15:0. Field position 0 is bits 15:12, position 1 is bits 11:8, position 2 is bits 7:4 and position 3 is bits 3:0. The field map is as follows. Address 0: position 0 is source 0 and position 1 is source 1. Address 1: position 0 is source 4 and position 3 is source 9. Address 2: position 0 is source 10, position 1 is source 11 and position 3 is source 12. A non-zero field enables its source at that level, and writing zero disables the source.
- R3: Two fields are group fields. Address 0 position 2 covers sources 2 and 3. Address 1 position 2 covers sources 5 to 8. One write to a group field enables every member at the same level.
- R4: Sources 10, 11 and 12 are also gated by bits 8, 9 and 0 of the gate register. Such a source is enabled only when both its field and its gate bit are non-zero.
- R5: A write to word address 4 sets the stored gate value to the old value OR the write data.
- R6: A write to word address 5 clears every stored gate bit where the write data has a 1.
- R7: A read at address 4 or at address 5 returns the stored gate value. A read at addresses 0 to 2 returns the level register, zero-extended.
- R8: The fields at address 1 position 1, address 2 position 2, and all of address 0 position 3, are stored and read back but enable no source. Addresses 3, 6 and 7 read zero, and writes to them change nothing.
- R9: Among the sources that are both requesting and enabled, the highest level wins, and equal levels go to the lowest source index. The vector codes for sources 0 to 12 are 0x400, 0x420, 0x440, 0x460, 0x560, 0x700, 0x720, 0x740, 0x760, 0x600, 0xB00, 0xB80 and 0xA00. When nothing wins, the level and vector outputs are zero.
- R10: Rewriting a register with its current value leaves the outputs unchanged. The gate register changes only on writes to addresses 4 and 5.
- R11: The outputs are registered. A change on `req_i` shows at the outputs after one rising edge. A register write shows after two rising edges: one for the write itself and one for the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 13 | Level interrupt requests, one per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | An enabled source is requesting |
| irq_level_o | output | 4 | Level of the winning source |
| irq_vector_o | output | 12 | Vector code of the winning source |

## Verification
A change of a request input is due at the outputs after exactly one rising edge. A register write is due after two: the edge that stores it and the edge that registers the arbitration result. Read data is due in the same cycle the address is driven. The bench drives inputs and samples outputs on falling edges only. Its behavioural model computes each edge's result from the register state before that edge, so the comparison made on every clock lines up with these latencies. The directed checks sample after the matching number of edges, and one of them also samples before the edge to show that the old value is still held.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 13;
  localparam int NUM_PREG  = 3;
  localparam int FLD_PER   = 4;
  localparam int FIELD_W   = 4;
  localparam int PREG_W    = FLD_PER * FIELD_W;
  localparam int NUM_FLD   = NUM_PREG * FLD_PER;
  localparam int MASK_W    = 32;
  localparam int VEC_W     = 12;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 32;
  localparam int GATE_SET  = 4;
  localparam int GATE_CLR  = 5;

  typedef logic [NUM_SRC-1:0] src_set_t;

  // sources referenced by priority field f (f = reg*FLD_PER + position)
  function automatic src_set_t field_members(int f);
    src_set_t m;
    m = '0;
    case (f)
      0:  m[0] = 1'b1;
      1:  m[1] = 1'b1;
      2:  m[3:2] = 2'b11;
      4:  m[4] = 1'b1;
      6:  m[8:5] = 4'hf;
      7:  m[9] = 1'b1;
      8:  m[10] = 1'b1;
      9:  m[11] = 1'b1;
      11: m[12] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // sources referenced by gate bit b
  function automatic src_set_t gate_members(int b);
    src_set_t m;
    m = '0;
    case (b)
      0: m[12] = 1'b1;
      8: m[10] = 1'b1;
      9: m[11] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(int s);
    logic [VEC_W-1:0] v;
    case (s)
      0:  v = 12'h400;
      1:  v = 12'h420;
      2:  v = 12'h440;
      3:  v = 12'h460;
      4:  v = 12'h560;
      5:  v = 12'h700;
      6:  v = 12'h720;
      7:  v = 12'h740;
      8:  v = 12'h760;
      9:  v = 12'h600;
      10: v = 12'hb00;
      11: v = 12'hb80;
      12: v = 12'ha00;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_PREG-1:0][PREG_W-1:0]  prio_o,
  output logic [MASK_W-1:0]                gate_o
);
  logic [NUM_PREG-1:0][PREG_W-1:0] prio_q;
  logic [MASK_W-1:0]               gate_q;

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_preg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  prio_q[p] <= '0;
      else if (we_i && addr_i == ADDR_W'(p))        prio_q[p] <= wdata_i[PREG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else if (we_i && addr_i == ADDR_W'(GATE_SET)) gate_q <= gate_q | wdata_i[MASK_W-1:0];
    else if (we_i && addr_i == ADDR_W'(GATE_CLR)) gate_q <= gate_q & ~wdata_i[MASK_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PREG; p++)
      if (addr_i == ADDR_W'(p)) rdata_o = DATA_W'(prio_q[p]);
    if (addr_i == ADDR_W'(GATE_SET) || addr_i == ADDR_W'(GATE_CLR))
      rdata_o = DATA_W'(gate_q);
  end

  assign prio_o = prio_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/intc_enable_map.sv
module intc_enable_map
  import intc_pkg::*;
(
  input  logic [NUM_PREG-1:0][PREG_W-1:0]  prio_i,
  input  logic [MASK_W-1:0]                gate_i,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [NUM_SRC-1:0][FIELD_W-1:0]  lvl_o
);
  always_comb begin
    src_set_t             mem;
    logic [FIELD_W-1:0]   fv;
    logic                 all_ok;
    logic                 has_ref;
    for (int s = 0; s < NUM_SRC; s++) begin
      all_ok   = 1'b1;
      has_ref  = 1'b0;
      lvl_o[s] = '0;
      for (int f = 0; f < NUM_FLD; f++) begin
        mem = field_members(f);
        fv  = prio_i[f / FLD_PER][PREG_W-1-(f % FLD_PER)*FIELD_W -: FIELD_W];
        if (mem[s]) begin
          has_ref = 1'b1;
          if (fv == '0) all_ok = 1'b0;
          if (fv > lvl_o[s]) lvl_o[s] = fv;
        end
      end
      // every gate bit naming this source must also be set
      for (int b = 0; b < MASK_W; b++) begin
        mem = gate_members(b);
        if (mem[s]) begin
          has_ref = 1'b1;
          if (!gate_i[b]) all_ok = 1'b0;
        end
      end
      en_o[s] = all_ok && has_ref;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]               req_i,
  input  logic [NUM_SRC-1:0]               en_i,
  input  logic [NUM_SRC-1:0][FIELD_W-1:0]  lvl_i,
  output logic                             irq_o,
  output logic [FIELD_W-1:0]               lvl_o,
  output logic [VEC_W-1:0]                 vec_o
);
  always_comb begin
    irq_o = 1'b0;
    lvl_o = '0;
    vec_o = '0;
    // strict compare keeps the lowest index on a tie
    for (int s = 0; s < NUM_SRC; s++) begin
      if (req_i[s] && en_i[s] && lvl_i[s] > lvl_o) begin
        irq_o = 1'b1;
        lvl_o = lvl_i[s];
        vec_o = src_vector(s);
      end
    end
  end
endmodule

// File: rtl/intc_grouped.sv
module intc_grouped
  import intc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  irq_o,
  output logic [FIELD_W-1:0]    irq_level_o,
  output logic [VEC_W-1:0]      irq_vector_o
);
  logic [NUM_PREG-1:0][PREG_W-1:0] prio_q;
  logic [MASK_W-1:0]               mask_q;
  logic [NUM_SRC-1:0]              src_en;
  logic [NUM_SRC-1:0][FIELD_W-1:0] src_lvl;
  logic                            win_irq;
  logic [FIELD_W-1:0]              win_lvl;
  logic [VEC_W-1:0]                win_vec;

  intc_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .prio_o  (prio_q),
    .gate_o  (mask_q)
  );

  intc_enable_map u_map (
    .prio_i (prio_q),
    .gate_i (mask_q),
    .en_o   (src_en),
    .lvl_o  (src_lvl)
  );

  intc_arbiter u_arb (
    .req_i (req_i),
    .en_i  (src_en),
    .lvl_i (src_lvl),
    .irq_o (win_irq),
    .lvl_o (win_lvl),
    .vec_o (win_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o        <= 1'b0;
      irq_level_o  <= '0;
      irq_vector_o <= '0;
    end else begin
      irq_o        <= win_irq;
      irq_level_o  <= win_lvl;
      irq_vector_o <= win_vec;
    end
  end
endmodule

// File: rtl/intc_grouped_chk.sv
module intc_grouped_chk
  import intc_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  req_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [MASK_W-1:0]   mask_q,
  input logic                irq_o,
  input logic [FIELD_W-1:0]  irq_level_o,
  input logic [VEC_W-1:0]    irq_vector_o
);
  logic wr_set, wr_clr;
  assign wr_set = bus_we_i && bus_addr_i == ADDR_W'(GATE_SET);
  assign wr_clr = bus_we_i && bus_addr_i == ADDR_W'(GATE_CLR);

  assert_idle_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_level_o == '0 && irq_vector_o == '0));

  assert_level_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_level_o != '0);

  assert_no_req_no_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> !irq_o);

  assert_gate_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> mask_q == ($past(mask_q) | $past(bus_wdata_i)));

  assert_gate_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> mask_q == ($past(mask_q) & ~$past(bus_wdata_i)));

  assert_gate_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(mask_q));

  assert_gate_needed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_vector_o == 12'hb00) |-> $past(mask_q[8]));
endmodule

bind intc_grouped intc_grouped_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .mask_q       (mask_q),
  .irq_o        (irq_o),
  .irq_level_o  (irq_level_o),
  .irq_vector_o (irq_vector_o)
);

// File: tb/tb_intc_grouped.sv
`timescale 1ns/1ps
module tb_intc_grouped;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] req = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  irq_level;
  logic [11:0] irq_vector;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_grouped dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .irq_level_o(irq_level), .irq_vector_o(irq_vector)
  );

  // reference tables: level register, field position, gate bit (-1 none), vector
  int s_reg [13] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 2, 2, 2};
  int s_pos [13] = '{0, 1, 2, 2, 0, 2, 2, 2, 2, 3, 0, 1, 3};
  int s_gate[13] = '{-1, -1, -1, -1, -1, -1, -1, -1, -1, -1, 8, 9, 0};
  int s_vec [13] = '{'h400, 'h420, 'h440, 'h460, 'h560, 'h700, 'h720,
                     'h740, 'h760, 'h600, 'hb00, 'hb80, 'ha00};

  int          m_prio[3];
  logic [31:0] m_gate;
  logic        e_irq;
  int          e_lvl, e_vec;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prio = '{0, 0, 0}; m_gate = '0; e_irq = 0; e_lvl = 0; e_vec = 0;
    end else begin
      int bl, bv;
      bl = 0; bv = 0;
      for (int s = 0; s < 13; s++) begin
        int l;
        l = (m_prio[s_reg[s]] >> (12 - 4 * s_pos[s])) & 15;
        if (req[s] && l != 0 && (s_gate[s] < 0 || m_gate[s_gate[s]]) && l > bl) begin
          bl = l; bv = s_vec[s];
        end
      end
      e_irq = (bl != 0); e_lvl = bl; e_vec = bv;
      if (bus_we) begin
        if (bus_addr < 3) m_prio[bus_addr] = int'(bus_wdata[15:0]);
        else if (bus_addr == 4) m_gate = m_gate | bus_wdata;
        else if (bus_addr == 5) m_gate = m_gate & ~bus_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // compare registered outputs against the model on every clock
  always @(negedge clk) begin
    if (rst_ni && !done)
      chk("R11 cycle model", {15'd0, irq, irq_level, irq_vector},
          {15'd0, e_irq, 4'(e_lvl), 12'(e_vec)});
  end

  task automatic out_is(input string tag, input logic i, input int l, input int v);
    chk(tag, {15'd0, irq, irq_level, irq_vector}, {15'd0, i, 4'(l), 12'(v)});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_req(input logic [12:0] v);
    req = v;
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    bus_addr = 3'(a);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    out_is("R1 reset outputs", 0, 0, 0);
    rd("R1 reset level reg", 0, 0);
    rd("R1 reset gate", 4, 0);

    set_req(13'h1fff);
    out_is("R2 nothing enabled", 0, 0, 0);
    wr(0, 32'h5000);
    out_is("R2 field bits 15:12", 1, 5, 'h400);

    wr(0, 32'h5070);
    out_is("R3 timer group level", 1, 7, 'h440);
    set_req(13'h0008);
    out_is("R3 second group member", 1, 7, 'h460);

    wr(0, 32'h7700);
    set_req(13'h0003);
    out_is("R9 tie to lower index", 1, 7, 'h400);
    set_req(13'h0002);
    out_is("R9 single requester", 1, 7, 'h420);

    wr(0, 32'h7700);
    out_is("R10 same value rewrite", 1, 7, 'h420);

    wr(0, 32'h0);
    set_req(13'h1fff);
    out_is("R2 zero disables", 0, 0, 0);

    wr(2, 32'h9000);
    set_req(13'h0400);
    out_is("R4 gate bit clear blocks", 0, 0, 0);
    wr(4, 32'h100);
    out_is("R4 field and gate set", 1, 9, 'hb00);
    rd("R7 read set address", 4, 32'h100);
    rd("R7 read clear address", 5, 32'h100);
    wr(4, 32'h201);
    rd("R5 set ORs in", 4, 32'h301);
    wr(5, 32'h100);
    rd("R6 clear removes ones", 5, 32'h201);
    out_is("R6 cleared gate blocks", 0, 0, 0);

    wr(1, 32'h0f00);
    set_req(13'h1fff);
    out_is("R8 reserved field no effect", 0, 0, 0);
    rd("R8 reserved field stored", 1, 32'h0f00);
    wr(3, 32'hffff);
    rd("R8 unmapped reads zero", 3, 0);
    rd("R7 level reg read", 2, 32'h9000);
    out_is("R8 unmapped write no effect", 0, 0, 0);

    wr(1, 32'h0030);
    set_req(13'h0080);
    out_is("R3 serial group member", 1, 3, 'h740);

    wr(1, 32'h4030);
    set_req(13'h0110);
    out_is("R9 higher level wins", 1, 4, 'h560);

    req = '0;
    #1;
    out_is("R11 held before edge", 1, 4, 'h560);
    @(negedge clk);
    out_is("R11 one edge after req", 0, 0, 0);

    wr(2, 32'h9003);
    set_req(13'h1000);
    out_is("R4 bus error gated by bit 0", 1, 3, 'ha00);
    set_req(13'h1400);
    wr(4, 32'h100);
    out_is("R9 gated source wins", 1, 9, 'hb00);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule